// File: doc/BRIEF.md
# MDIO Management Register Controller

This block is a management-bus master for Ethernet PHYs, driven through a small bank of 32-bit registers. Software first sets a clock divisor and an enable flag. For a register write it loads the data word and then writes one packed control word. That word carries the PHY address, the PHY register address, a read or write request and an initiate flag. The block then clocks out one standard Clause-22 management frame on MDC and MDIO. Software polls a ready flag in the same control word to learn when the frame has finished.

For a read, the block releases MDIO from the turnaround onwards and shifts in the 16 data bits the PHY returns. That value is then visible at the read-data offset. MDC runs freely whenever the enable flag is set, and every frame starts on an MDC falling edge. Register offsets are word indices on a two-bit address: 0 configuration, 1 control, 2 write data, 3 read data.

Top module: `mdio_regctl`

## Requirements
- R1: After reset the configuration word reads 29 (divisor 29, enable bit 6 clear), the control word reads 0x00000080 (only ready set) and the read-data word reads 0.
- R2: With enable (configuration bit 6) set, MDC has a period of 2 × (divisor + 1) clock cycles, where the divisor is configuration bits 5:0. With enable clear, MDC stays low.
- R3: A control write with initiate (bit 11) set while enable is clear starts no frame, and ready (control bit 7) stays 1.
- R4: Ready reads 0 from the accepted initiate until the frame ends, then reads 1 again. The initiate bit always reads back as 0.
- R5: A write frame (control bit 14) carries, MSB first: 32 ones, 01, opcode 01, PHY address (control bits 28:24), register address (control bits 20:16), turnaround 10 and the 16-bit write data. MDIO changes only on MDC falling edges, and the output enable is high for the whole frame.
- R6: A read frame (control bit 15) carries opcode 10. The output enable drops from the turnaround to the end of the frame. The 16 bits sampled on MDC rising edges, MSB first, appear in read-data bits 15:0 once ready returns.
- R7: While a frame runs, control writes are ignored: no second frame starts, the current frame is unchanged, and the stored PHY address and opcode fields keep their values.
- R8: A read that returns all ones stores 0xFFFF unchanged and completes with ready 1, like any other read.
- R9: The write data is taken when initiate is accepted. Rewriting the data register during the frame does not change the frame, but the register itself does take the new value.
- R10: A control write with initiate set but neither bit 15 nor bit 14 set starts no frame. If both are set, the frame is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset of the register accessed |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the offset on bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the pad |

## Verification
The bench builds the block with its default parameters: a 6-bit divisor field and a reset divisor of 29. It then programs divisor 2 at run time, so that a full 64-bit frame fits in a few hundred clocks and several write and read frames can be compared bit by bit. It also programs divisor 0, which reaches the fastest MDC. At that setting the bench's PHY model changes MDIO one clock before the capture edge. This proves that capture is tied to the MDC rising edge and not to an internal count. The reset divisor of 29 is checked only by readback and never used for a frame.

// File: rtl/mdio_regctl_pkg.sv
package mdio_regctl_pkg;

  localparam int PRE_BITS   = 32;
  localparam int ADR_W      = 5;
  localparam int MD_DATA_W  = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + ADR_W + ADR_W + 2 + MD_DATA_W;

  localparam logic [1:0] OFS_CFG   = 2'd0;
  localparam logic [1:0] OFS_CTRL  = 2'd1;
  localparam logic [1:0] OFS_WDATA = 2'd2;
  localparam logic [1:0] OFS_RDATA = 2'd3;

  localparam int CFG_EN_BIT   = 6;
  localparam int CTL_PHY_LSB  = 24;
  localparam int CTL_REG_LSB  = 16;
  localparam int CTL_RD_BIT   = 15;
  localparam int CTL_WR_BIT   = 14;
  localparam int CTL_GO_BIT   = 11;
  localparam int CTL_RDY_BIT  = 7;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ARMED = 2'd1,
    ENG_SHIFT = 2'd2
  } eng_state_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic                 rd,
    input logic [ADR_W-1:0]     phy,
    input logic [ADR_W-1:0]     regad,
    input logic [MD_DATA_W-1:0] wd
  );
    return {{PRE_BITS{1'b1}}, 2'b01,
            (rd ? 2'b10 : 2'b01), phy, regad,
            (rd ? 2'b11 : 2'b10),
            (rd ? {MD_DATA_W{1'b0}} : wd)};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = en && (cnt >= div);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick &&  mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_regctl_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int RD_W  = MD_DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             start_rd,
  input  logic [NBITS-1:0] frame,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [RD_W-1:0]  rd_data
);

  localparam int IDX_W    = $clog2(NBITS);
  localparam int DATA_POS = NBITS - RD_W;
  localparam int TA_POS   = DATA_POS - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

  eng_state_t       state;
  logic [NBITS-1:0] sreg;
  logic [IDX_W-1:0] idx;
  logic             is_rd;
  logic [RD_W-1:0]  cap;

  assign busy = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      sreg    <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      cap     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (!en && state != ENG_IDLE) begin
      state   <= ENG_IDLE;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            sreg  <= frame;
            is_rd <= start_rd;
            state <= ENG_ARMED;
          end
        end
        ENG_ARMED: begin
          if (fall_stb) begin
            mdio_o  <= sreg[NBITS-1];
            sreg    <= sreg << 1;
            idx     <= '0;
            mdio_oe <= 1'b1;
            state   <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (rise_stb && is_rd && int'(idx) >= DATA_POS)
            cap <= {cap[RD_W-2:0], mdio_i};
          if (fall_stb) begin
            if (idx == LAST_IDX) begin
              state   <= ENG_IDLE;
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b0;
              if (is_rd) rd_data <= cap;
            end else begin
              idx     <= idx + 1'b1;
              mdio_o  <= sreg[NBITS-1];
              sreg    <= sreg << 1;
              mdio_oe <= !(is_rd && (int'(idx) + 1) >= TA_POS);
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_regctl.sv
module mdio_regctl
  import mdio_regctl_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int DIV_RESET = 29
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wen,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [DIV_W-1:0]     cfg_div;
  logic                 cfg_en;
  logic [ADR_W-1:0]     ctl_phy;
  logic [ADR_W-1:0]     ctl_reg;
  logic                 ctl_rd;
  logic                 ctl_wr;
  logic [MD_DATA_W-1:0] wdata_q;
  logic [MD_DATA_W-1:0] eng_rdata;
  logic                 eng_busy;
  logic                 rise_stb;
  logic                 fall_stb;
  logic                 ctrl_wr;
  logic                 accept;
  logic                 req_rd;
  logic                 req_wr;
  logic [FRAME_BITS-1:0] frame;
  logic [31:0]          cfg_word;
  logic [31:0]          ctl_word;

  assign ctrl_wr = bus_wen && (bus_addr == OFS_CTRL);
  assign req_rd  = bus_wdata[CTL_RD_BIT];
  assign req_wr  = bus_wdata[CTL_WR_BIT];
  assign accept  = ctrl_wr && bus_wdata[CTL_GO_BIT] && cfg_en && !eng_busy
                   && (req_rd || req_wr);
  assign frame   = build_frame(req_rd,
                               bus_wdata[CTL_PHY_LSB +: ADR_W],
                               bus_wdata[CTL_REG_LSB +: ADR_W],
                               wdata_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div <= DIV_W'(DIV_RESET);
      cfg_en  <= 1'b0;
      ctl_phy <= '0;
      ctl_reg <= '0;
      ctl_rd  <= 1'b0;
      ctl_wr  <= 1'b0;
      wdata_q <= '0;
    end else if (bus_wen) begin
      case (bus_addr)
        OFS_CFG: begin
          cfg_div <= bus_wdata[DIV_W-1:0];
          cfg_en  <= bus_wdata[CFG_EN_BIT];
        end
        OFS_CTRL: begin
          if (!eng_busy) begin
            ctl_phy <= bus_wdata[CTL_PHY_LSB +: ADR_W];
            ctl_reg <= bus_wdata[CTL_REG_LSB +: ADR_W];
            ctl_rd  <= req_rd;
            ctl_wr  <= req_wr;
          end
        end
        OFS_WDATA: wdata_q <= bus_wdata[MD_DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[DIV_W-1:0]  = cfg_div;
    cfg_word[CFG_EN_BIT] = cfg_en;
    ctl_word = '0;
    ctl_word[CTL_PHY_LSB +: ADR_W] = ctl_phy;
    ctl_word[CTL_REG_LSB +: ADR_W] = ctl_reg;
    ctl_word[CTL_RD_BIT]  = ctl_rd;
    ctl_word[CTL_WR_BIT]  = ctl_wr;
    ctl_word[CTL_RDY_BIT] = !eng_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_CFG:   bus_rdata <= cfg_word;
        OFS_CTRL:  bus_rdata <= ctl_word;
        OFS_WDATA: bus_rdata <= 32'(wdata_q);
        default:   bus_rdata <= 32'(eng_rdata);
      endcase
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .div      (cfg_div),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng #(.NBITS(FRAME_BITS), .RD_W(MD_DATA_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .start    (accept),
    .start_rd (req_rd),
    .frame    (frame),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (eng_rdata)
  );

endmodule

// File: rtl/mdio_regctl_chk.sv
module mdio_regctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       busy,
  input logic       accept,
  input logic       ctrl_wr,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [4:0] phy
);

  a_r2_mdc_rises_only_enabled: assert property (@(posedge clk) disable iff (rst)
    (mdc && !$past(mdc)) |-> $past(en));

  a_r4_oe_within_frame: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  a_r4_busy_from_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept));

  a_r3_busy_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en));

  a_r7_fields_held: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> $stable(phy));

  a_r5_data_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

endmodule

bind mdio_regctl mdio_regctl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (cfg_en),
  .busy    (eng_busy),
  .accept  (accept),
  .ctrl_wr (ctrl_wr),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .phy     (ctl_phy)
);

// File: tb/mdio_regctl_tb_top.sv
module mdio_regctl_tb_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int mdc_rises = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] bits;
    logic        rd;
    logic [15:0] resp;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_NS/2) clk = ~clk;

  mdio_regctl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) mdc_rises++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic rd, input logic wr, input logic go,
                                      input logic [4:0] phy, input logic [4:0] ra);
    return (32'(phy) << 24) | (32'(ra) << 16) | (32'(rd) << 15) |
           (32'(wr) << 14) | (32'(go) << 11);
  endfunction

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
  endfunction

  task automatic wait_idle(input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd1, v);
      if (v[7]) break;
    end
    chk(req, 64'(v[7]), 64'd1);
  endtask

  // driver: push expectation, start frame, check ready dropped
  task automatic start_frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] d, input string tag);
    exp_t e;
    logic [31:0] v;
    e.bits = exp_frame(rd, phy, ra, d);
    e.rd = rd; e.resp = d; e.tag = tag;
    q.push_back(e);
    if (!rd) bus_write(2'd2, 32'(d));
    bus_write(2'd1, ctl(rd, !rd, 1'b1, phy, ra));
    bus_read(2'd1, v);
    chk("R4 ready low during frame", 64'(v[7]), 64'd0);
    chk("R4 initiate reads zero", 64'(v[11]), 64'd0);
  endtask

  // monitor / PHY model
  initial begin
    forever begin
      exp_t e;
      logic [63:0] got;
      int oe_bad;
      @(posedge mdio_oe);
      #1;
      if (q.size() == 0) begin
        chk("R7 unexpected frame", 64'd1, 64'd0);
        continue;
      end
      e = q.pop_front();
      got = '0;
      oe_bad = 0;
      for (int i = 0; i < 64; i++) begin
        @(posedge mdc); #1;
        got[63-i] = mdio_o;
        if (e.rd && i >= 46) begin
          if (mdio_oe) oe_bad++;
        end else begin
          if (!mdio_oe) oe_bad++;
        end
        if (e.rd && (i + 1) >= 48 && (i + 1) <= 63) begin
          @(negedge mdc); #1;
          mdio_i = e.resp[63-(i+1)];
        end
      end
      mdio_i = 1'b1;
      if (e.rd) chk({e.tag, " frame header"}, 64'(got[63:18]), 64'(e.bits[63:18]));
      else      chk({e.tag, " frame bits"}, got, e.bits);
      chk({e.tag, " output enable pattern"}, 64'(oe_bad), 64'd0);
    end
  end

  // watchdog
  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    realtime t0, t1;
    int r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, v); chk("R1 config reset", 64'(v), 64'd29);
    bus_read(2'd1, v); chk("R1 control reset", 64'(v), 64'h80);
    bus_read(2'd3, v); chk("R1 read data reset", 64'(v), 64'd0);

    // R2 quiet, R3 initiate while disabled
    chk("R2 mdc quiet while disabled", 64'(mdc_rises), 64'd0);
    bus_write(2'd1, ctl(1'b1, 1'b0, 1'b1, 5'd1, 5'd1));
    repeat (100) @(negedge clk);
    bus_read(2'd1, v);
    chk("R3 ready stays high when disabled", 64'(v[7]), 64'd1);
    chk("R3 no mdc when disabled", 64'(mdc_rises), 64'd0);
    chk("R3 output enable low", 64'(mdio_oe), 64'd0);

    // R2 period at divisor 2
    bus_write(2'd0, 32'h40 | 32'd2);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R2 mdc period div 2", 64'(int'((t1 - t0) / CLK_NS)), 64'd6);

    // R5 write frame
    start_frame(1'b0, 5'h13, 5'h0A, 16'hA5C3, "R5 write");
    wait_idle("R4 ready back after write");

    // R6 read frame
    start_frame(1'b1, 5'h03, 5'h01, 16'h1808, "R6 read");
    wait_idle("R4 ready back after read");
    bus_read(2'd3, v); chk("R6 read data stored", 64'(v), 64'h1808);

    // R8 all ones
    start_frame(1'b1, 5'h1F, 5'h01, 16'hFFFF, "R8 read");
    wait_idle("R8 ready after all-ones read");
    bus_read(2'd3, v); chk("R8 all-ones stored", 64'(v), 64'hFFFF);

    // R9 data rewritten mid-frame
    start_frame(1'b0, 5'h02, 5'h04, 16'h3C5A, "R9 write");
    bus_write(2'd2, 32'h0000_1234);
    wait_idle("R9 ready after write");
    bus_read(2'd2, v); chk("R9 data register updated", 64'(v), 64'h1234);

    // R7 control write during a frame
    start_frame(1'b0, 5'h07, 5'h09, 16'h0F0F, "R7 write");
    bus_write(2'd1, ctl(1'b1, 1'b0, 1'b1, 5'h1F, 5'h1E));
    wait_idle("R7 ready after frame");
    bus_read(2'd1, v);
    chk("R7 phy field kept", 64'(v[28:24]), 64'h07);
    chk("R7 opcode kept", 64'(v[15:14]), 64'b01);
    repeat (200) @(negedge clk);
    chk("R7 no extra frame", 64'(mdio_oe), 64'd0);

    // R10 no opcode bits
    bus_write(2'd1, ctl(1'b0, 1'b0, 1'b1, 5'h05, 5'h05));
    bus_read(2'd1, v);
    chk("R10 no frame without opcode", 64'(v[7]), 64'd1);
    repeat (100) @(negedge clk);
    chk("R10 output enable low", 64'(mdio_oe), 64'd0);
    // R10 both bits -> read
    begin
      exp_t e;
      e.bits = exp_frame(1'b1, 5'h0C, 5'h02, 16'h0);
      e.rd = 1'b1; e.resp = 16'h8421; e.tag = "R10 both-bits read";
      q.push_back(e);
      bus_write(2'd1, ctl(1'b1, 1'b1, 1'b1, 5'h0C, 5'h02));
      wait_idle("R10 ready after both-bits frame");
      bus_read(2'd3, v); chk("R10 both bits read data", 64'(v), 64'h8421);
    end

    // R2 divisor 0 and fast read
    bus_write(2'd0, 32'h40);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R2 mdc period div 0", 64'(int'((t1 - t0) / CLK_NS)), 64'd2);
    start_frame(1'b1, 5'h11, 5'h1B, 16'h0001, "R6 fast read");
    wait_idle("R6 ready after fast read");
    bus_read(2'd3, v); chk("R6 fast read data", 64'(v), 64'h0001);

    // R2 disable stops mdc
    bus_write(2'd0, 32'd2);
    repeat (3) @(negedge clk);
    r0 = mdc_rises;
    repeat (50) @(negedge clk);
    chk("R2 mdc stops when disabled", 64'(mdc_rises - r0), 64'd0);
    chk("R2 mdc low when disabled", 64'(mdc), 64'd0);

    chk("scoreboard drained", 64'(q.size()), 64'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule